// File: doc/BRIEF.md
# Dual-Interrupt 32-Pin I/O Bank

This block is one bank of 32 general-purpose pins controlled through a small word-wide register port. Each pin is an input or an output depending on its direction bit. Output pins drive a latch that software can overwrite whole or change through write-one set and clear ports, so it never needs a read-modify-write. Input levels pass through a two-flop synchroniser and can be read back at any time.

Every pin can flag an event on a low level, a high level, a rising edge or a falling edge. Each of the four detect types has its own per-pin enable. The event of a pin is the OR of its enabled detections, and it latches into the raw status of two independent interrupt lines. Each line has its own enable mask and its own write-one-to-clear status. Its output is a registered OR of its masked status.

A bus access is a one-cycle `busSel` pulse. A write takes effect at the clock edge that samples it. A read returns its data with `busRdy` one cycle later.

Top module: `pinbank_dualirq`

## Requirements
- R1: After reset, the direction register (0x134) reads 0xFFFFFFFF, so every pin is an input, `pinOe` is zero, the output latch reads 0, both `irqLine` bits are 0, and offset 0x000 reads the constant 0x50600801.
- R2: Direction bit n = 1 makes pin n an input and bit n = 0 makes it drive; `pinOe` is the bitwise inverse of the direction register and `pinOut` always shows the output latch.
- R3: The output latch reads and writes at 0x13C. Writing a mask to 0x194 sets the selected latch bits and writing a mask to 0x190 clears them; mask bits of 0 leave latch bits unchanged.
- R4: Offset 0x138 returns the pin levels after a two-flop synchroniser: a read sampled one edge after a pin change still shows the old level, and a read sampled three edges after it shows the new one.
- R5: Per-pin detect enables are at 0x140 (low level), 0x144 (high level), 0x148 (rising edge) and 0x14C (falling edge). Several may be on at once, and any enabled detection of pin n sets bit n of both raw status registers (0x24 for line 0, 0x28 for line 1).
- R6: Writing 1 to bit n of masked status 0x2C (line 0) or 0x30 (line 1) clears raw bit n of that line only. Writing 0 has no effect, and an edge event stays cleared once acknowledged.
- R7: The enable mask of line 0 is set through 0x34 and cleared through 0x3C, and that of line 1 through 0x38 and 0x40, both with write-one semantics. Reads of either port of a line return its mask.
- R8: Masked status reads as raw status AND enable mask. `irqLine[k]` is high one cycle after any masked bit of line k is set, and low one cycle after none is.
- R9: A level detect whose condition still holds sets its status bit again right after software clears it.
- R10: When a status clear and a new event hit the same bit in the same cycle, the bit stays set.
- R11: Reads of unmapped offsets and of the latch set and clear ports return 0. Writes to unmapped or read-only offsets change no state.
- R12: `busRdy` is high exactly in the cycle after a cycle with `busSel` high, and `busRData` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, valid while busRdy is high |
| busRdy | output | 1 | Access complete strobe |
| pinIn | input | 32 | Pin levels from the pads |
| pinOut | output | 32 | Output latch value |
| pinOe | output | 32 | Per-pin drive enable, 1 = drive |
| irqLine | output | 2 | Interrupt outputs, bit k for line k |

## Verification
On every cycle the assertions check four things. An event always lands in both raw status registers. A clear of a status bit removes it unless an event arrives with it. The enable masks and the direction register stay unchanged without their write strobes. An interrupt line drops once its masked status is empty. Only the bench scenarios can show the cross-register behaviour. These are the detect type each offset selects and the synchroniser latency seen through the read port. They also include the re-arming of level detects after a clear, the per-line independence of acknowledges, and the exact cycle where a clear and an edge collide.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int WORD_W = 32;
  localparam int NLINE  = 2;
  localparam int NDET   = 4;
  localparam logic [WORD_W-1:0] REV_ID = 32'h5060_0801;

  localparam int OFF_REV    = 'h000;
  localparam int OFF_RAW0   = 'h024;
  localparam int OFF_RAW1   = 'h028;
  localparam int OFF_MSK0   = 'h02C;
  localparam int OFF_MSK1   = 'h030;
  localparam int OFF_ENSET0 = 'h034;
  localparam int OFF_ENSET1 = 'h038;
  localparam int OFF_ENCLR0 = 'h03C;
  localparam int OFF_ENCLR1 = 'h040;
  localparam int OFF_DIR    = 'h134;
  localparam int OFF_DIN    = 'h138;
  localparam int OFF_LATCH  = 'h13C;
  localparam int OFF_DETLO  = 'h140;
  localparam int OFF_DETHI  = 'h144;
  localparam int OFF_DETRI  = 'h148;
  localparam int OFF_DETFA  = 'h14C;
  localparam int OFF_LCLR   = 'h190;
  localparam int OFF_LSET   = 'h194;

  typedef enum logic [3:0] {
    RD_NONE, RD_REV, RD_DIR, RD_LATCH, RD_DIN,
    RD_DLO, RD_DHI, RD_DRI, RD_DFA,
    RD_RAW0, RD_RAW1, RD_MSK0, RD_MSK1, RD_EN0, RD_EN1
  } rdSel_e;

  typedef struct packed {
    logic             wrDir;
    logic             wrLatch;
    logic             setLatch;
    logic             clrLatch;
    logic [NDET-1:0]  wrDet;
    logic [NLINE-1:0] enSet;
    logic [NLINE-1:0] enClr;
    logic [NLINE-1:0] stClr;
  } wrStrb_t;
endpackage

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrb_t           strb,
  output rdSel_e            rdSel,
  output logic              busRdy
);
  logic isWr;
  logic isRd;
  assign isWr = busSel && busWe;
  assign isRd = busSel && !busWe;

  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    case (busAddr)
      ADDR_W'(OFF_REV):    rdSel = RD_REV;
      ADDR_W'(OFF_RAW0):   rdSel = RD_RAW0;
      ADDR_W'(OFF_RAW1):   rdSel = RD_RAW1;
      ADDR_W'(OFF_MSK0):   begin rdSel = RD_MSK0; strb.stClr[0] = isWr; end
      ADDR_W'(OFF_MSK1):   begin rdSel = RD_MSK1; strb.stClr[1] = isWr; end
      ADDR_W'(OFF_ENSET0): begin rdSel = RD_EN0;  strb.enSet[0] = isWr; end
      ADDR_W'(OFF_ENSET1): begin rdSel = RD_EN1;  strb.enSet[1] = isWr; end
      ADDR_W'(OFF_ENCLR0): begin rdSel = RD_EN0;  strb.enClr[0] = isWr; end
      ADDR_W'(OFF_ENCLR1): begin rdSel = RD_EN1;  strb.enClr[1] = isWr; end
      ADDR_W'(OFF_DIR):    begin rdSel = RD_DIR;  strb.wrDir    = isWr; end
      ADDR_W'(OFF_DIN):    rdSel = RD_DIN;
      ADDR_W'(OFF_LATCH):  begin rdSel = RD_LATCH; strb.wrLatch = isWr; end
      ADDR_W'(OFF_DETLO):  begin rdSel = RD_DLO;  strb.wrDet[0] = isWr; end
      ADDR_W'(OFF_DETHI):  begin rdSel = RD_DHI;  strb.wrDet[1] = isWr; end
      ADDR_W'(OFF_DETRI):  begin rdSel = RD_DRI;  strb.wrDet[2] = isWr; end
      ADDR_W'(OFF_DETFA):  begin rdSel = RD_DFA;  strb.wrDet[3] = isWr; end
      ADDR_W'(OFF_LCLR):   strb.clrLatch = isWr;
      ADDR_W'(OFF_LSET):   strb.setLatch = isWr;
      default:             rdSel = RD_NONE;
    endcase
    if (!isRd) rdSel = RD_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdy <= 1'b0;
    else       busRdy <= busSel;
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/pinbank_dp.sv
module pinbank_dp
  import pinbank_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrb_t          strb,
  input  rdSel_e           rdSel,
  input  logic [W-1:0]     wrData,
  input  logic [W-1:0]     pinIn,
  output logic [W-1:0]     pinOut,
  output logic [W-1:0]     pinOe,
  output logic [W-1:0]     rdData,
  output logic [NLINE-1:0] irqLine
);
  logic [W-1:0] dirReg, latchReg;
  logic [W-1:0] syncA, syncB, prevS;
  logic [W-1:0] detEn  [NDET];
  logic [W-1:0] condVec[NDET];
  logic [W-1:0] enMask [NLINE];
  logic [W-1:0] rawSt  [NLINE];
  logic [W-1:0] mskSt  [NLINE];
  logic [W-1:0] clrMask[NLINE];
  logic [W-1:0] evtVec;
  logic [W-1:0] rdNext;

  // synchroniser and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevS <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevS <= syncB;
    end
  end

  // detect conditions: 0 low, 1 high, 2 rising, 3 falling
  assign condVec[0] = ~syncB;
  assign condVec[1] = syncB;
  assign condVec[2] = syncB & ~prevS;
  assign condVec[3] = ~syncB & prevS;

  always_comb begin
    evtVec = '0;
    for (int t = 0; t < NDET; t++) evtVec |= detEn[t] & condVec[t];
  end

  // pin control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= '1;
      latchReg <= '0;
    end else begin
      if (strb.wrDir) dirReg <= wrData;
      if (strb.wrLatch)       latchReg <= wrData;
      else if (strb.setLatch) latchReg <= latchReg | wrData;
      else if (strb.clrLatch) latchReg <= latchReg & ~wrData;
    end
  end

  assign pinOut = latchReg;
  assign pinOe  = ~dirReg;

  generate
    for (genvar t = 0; t < NDET; t++) begin : g_det
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             detEn[t] <= '0;
        else if (strb.wrDet[t]) detEn[t] <= wrData;
      end
    end

    for (genvar k = 0; k < NLINE; k++) begin : g_line
      assign clrMask[k] = strb.stClr[k] ? wrData : '0;
      assign mskSt[k]   = rawSt[k] & enMask[k];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enMask[k]  <= '0;
          rawSt[k]   <= '0;
          irqLine[k] <= 1'b0;
        end else begin
          if (strb.enSet[k])      enMask[k] <= enMask[k] | wrData;
          else if (strb.enClr[k]) enMask[k] <= enMask[k] & ~wrData;
          rawSt[k]   <= (rawSt[k] & ~clrMask[k]) | evtVec;
          irqLine[k] <= |mskSt[k];
        end
      end

      // R5
      evt_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
        (evtVec != '0) |=> ((rawSt[k] & $past(evtVec)) == $past(evtVec)));
      // R6
      st_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (clrMask[k] != '0) |=> ((rawSt[k] & $past(clrMask[k]) & ~$past(evtVec)) == '0));
      // R7
      en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !(strb.enSet[k] || strb.enClr[k]) |=> $stable(enMask[k]));
      // R8
      irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
        ((rawSt[k] & enMask[k]) == '0) |=> !irqLine[k]);
    end
  endgenerate

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirReg));

  always_comb begin
    case (rdSel)
      RD_REV:   rdNext = REV_ID;
      RD_DIR:   rdNext = dirReg;
      RD_LATCH: rdNext = latchReg;
      RD_DIN:   rdNext = syncB;
      RD_DLO:   rdNext = detEn[0];
      RD_DHI:   rdNext = detEn[1];
      RD_DRI:   rdNext = detEn[2];
      RD_DFA:   rdNext = detEn[3];
      RD_RAW0:  rdNext = rawSt[0];
      RD_RAW1:  rdNext = rawSt[1];
      RD_MSK0:  rdNext = mskSt[0];
      RD_MSK1:  rdNext = mskSt[1];
      RD_EN0:   rdNext = enMask[0];
      RD_EN1:   rdNext = enMask[1];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/pinbank_dualirq.sv
module pinbank_dualirq
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData,
  output logic              busRdy,
  input  logic [31:0]       pinIn,
  output logic [31:0]       pinOut,
  output logic [31:0]       pinOe,
  output logic [1:0]        irqLine
);
  wrStrb_t strb;
  rdSel_e  rdSel;

  pinbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .strb(strb), .rdSel(rdSel), .busRdy(busRdy)
  );

  pinbank_dp #(.W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wrData(busWData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .rdData(busRData),
    .irqLine(irqLine)
  );
endmodule

// File: tb/sim_pinbank_dualirq.sv
module sim_pinbank_dualirq;
  logic clk = 1'b0;
  logic rstN;
  logic busSel, busWe;
  logic [11:0] busAddr;
  logic [31:0] busWData;
  logic [31:0] busRData;
  logic busRdy;
  logic [31:0] pinIn;
  logic [31:0] pinOut, pinOe;
  logic [1:0] irqLine;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pinbank_dualirq #(.ADDR_W(12)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .busRdy(busRdy),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqLine(irqLine)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busSel = 1; busWe = 1; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    busSel = 1; busWe = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    chk(req, busRData, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [31:0] expL, en0, en1, inact, m;
    int pins[4];
    pins = '{0, 9, 16, 31};
    rstN = 0; busSel = 0; busWe = 0; busAddr = '0; busWData = '0; pinIn = '0;
    idle(3);
    rstN = 1;
    idle(1);

    // R1 reset state
    chk("R1 irq", {30'd0, irqLine}, 32'd0);
    chk("R1 pinOe", pinOe, 32'd0);
    rdChk("R1 rev", 12'h000, 32'h5060_0801);
    chk("R12 rdy high", {31'd0, busRdy}, 32'd1);
    idle(1);
    chk("R12 rdy low", {31'd0, busRdy}, 32'd0);
    rdChk("R1 dir", 12'h134, 32'hFFFF_FFFF);
    rdChk("R1 latch", 12'h13C, 32'd0);

    // R11 unmapped and read-only
    rdChk("R11 unmapped 0x004", 12'h004, 32'd0);
    rdChk("R11 unmapped 0x200", 12'h200, 32'd0);
    wr(12'h100, 32'd0);
    wr(12'h000, 32'd0);
    wr(12'h024, 32'hFFFF_FFFF);
    rdChk("R11 dir untouched", 12'h134, 32'hFFFF_FFFF);
    rdChk("R11 latch untouched", 12'h13C, 32'd0);
    rdChk("R11 rev untouched", 12'h000, 32'h5060_0801);

    // R3 latch set sweep
    expL = '0;
    for (int i = 0; i < 32; i++) begin
      wr(12'h194, 32'd1 << i);
      expL |= 32'd1 << i;
      rdChk("R3 set sweep", 12'h13C, expL);
    end
    wr(12'h190, 32'hAAAA_AAAA);
    expL &= ~32'hAAAA_AAAA;
    rdChk("R3 clear mask", 12'h13C, expL);
    wr(12'h190, 32'h0);
    rdChk("R3 zero mask", 12'h13C, expL);
    wr(12'h13C, 32'hA5C3_0F18);
    rdChk("R3 direct write", 12'h13C, 32'hA5C3_0F18);
    chk("R2 pinOut", pinOut, 32'hA5C3_0F18);
    rdChk("R11 set port reads 0", 12'h194, 32'd0);
    rdChk("R11 clr port reads 0", 12'h190, 32'd0);

    // R2 direction
    wr(12'h134, 32'h0000_FFFF);
    rdChk("R2 dir readback", 12'h134, 32'h0000_FFFF);
    chk("R2 pinOe", pinOe, 32'hFFFF_0000);

    // R4 input sampling latency
    pinIn = 32'h1234_5678;
    idle(4);
    rdChk("R4 settled", 12'h138, 32'h1234_5678);
    pinIn = 32'hCAFE_0001;
    rdChk("R4 early read old", 12'h138, 32'h1234_5678);
    idle(1);
    rdChk("R4 late read new", 12'h138, 32'hCAFE_0001);

    // R7 enable masks
    wr(12'h034, 32'hFFFF_FFFF);
    rdChk("R7 en0 set", 12'h034, 32'hFFFF_FFFF);
    wr(12'h03C, 32'hFFFF_0000);
    rdChk("R7 en0 clr", 12'h03C, 32'h0000_FFFF);
    wr(12'h038, 32'hFFFF_0000);
    rdChk("R7 en1 set", 12'h038, 32'hFFFF_0000);
    rdChk("R7 en1 via clr port", 12'h040, 32'hFFFF_0000);
    en0 = 32'h0000_FFFF;
    en1 = 32'hFFFF_0000;

    // R5 R6 R8 R9 detect sweep
    for (int t = 0; t < 4; t++) begin
      for (int j = 0; j < 4; j++) begin
        m = 32'd1 << pins[j];
        inact = (t == 0 || t == 3) ? 32'hFFFF_FFFF : 32'h0;
        pinIn = inact;
        idle(4);
        wr(12'h140 + 12'(4 * t), m);
        wr(12'h02C, 32'hFFFF_FFFF);
        wr(12'h030, 32'hFFFF_FFFF);
        idle(1);
        rdChk("R5 quiet before trigger", 12'h024, 32'd0);
        pinIn = inact ^ m;
        idle(4);
        rdChk("R5 raw0", 12'h024, m);
        rdChk("R5 raw1", 12'h028, m);
        rdChk("R8 masked0", 12'h02C, m & en0);
        rdChk("R8 masked1", 12'h030, m & en1);
        chk("R8 irq", {30'd0, irqLine}, {30'd0, |(m & en1), |(m & en0)});
        wr(12'h02C, m);
        idle(1);
        if (t < 2) rdChk("R9 level re-sets", 12'h024, m);
        else       rdChk("R6 edge cleared", 12'h024, 32'd0);
        rdChk("R6 other line kept", 12'h028, m);
        wr(12'h030, 32'd0);
        rdChk("R6 write zero no effect", 12'h028, m);
        wr(12'h140 + 12'(4 * t), 32'd0);
        pinIn = inact;
        idle(4);
        wr(12'h02C, 32'hFFFF_FFFF);
        wr(12'h030, 32'hFFFF_FFFF);
        idle(3);
        chk("R8 irq dropped", {30'd0, irqLine}, 32'd0);
      end
    end

    // R5 two detect types on one pin
    pinIn = 32'h0;
    idle(4);
    wr(12'h148, 32'h8);
    wr(12'h14C, 32'h8);
    wr(12'h02C, 32'hFFFF_FFFF);
    pinIn = 32'h8;
    idle(4);
    rdChk("R5 OR rise", 12'h024, 32'h8);
    wr(12'h02C, 32'h8);
    pinIn = 32'h0;
    idle(4);
    rdChk("R5 OR fall", 12'h024, 32'h8);
    wr(12'h148, 32'h0);
    wr(12'h14C, 32'h0);

    // R10 clear collides with edge event
    wr(12'h148, 32'h20);
    wr(12'h02C, 32'hFFFF_FFFF);
    wr(12'h030, 32'hFFFF_FFFF);
    idle(1);
    rdChk("R10 precleared", 12'h024, 32'd0);
    pinIn = 32'h20;
    idle(2);
    wr(12'h02C, 32'h20);
    rdChk("R10 event wins", 12'h024, 32'h20);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule